// File: doc/BRIEF.md
# SPI Master Peripheral-Select Decoder

This block drives the active-low peripheral-select lines of an SPI master. A configuration bit chooses one of two modes. In direct mode at most one line goes low. A 4-bit select code with several zero bits is resolved to the lowest-numbered zero bit. In decoded mode the 4-bit code goes onto the lines unchanged, so that an external 1-of-16 demultiplexer can address up to 15 peripherals. The all-ones code is kept as the idle value.

A second configuration bit picks where the code comes from. It is either a fixed field that software writes once, or a field carried with each transmit word. For each transfer the block also reports which of four per-select format/timing sets applies. It flags when no peripheral is targeted, and it enables mode-fault sensing only while the keep-select-active option is off.

A small state machine registers the outputs, so they change only at transfer boundaries. In `ST_IDLE` the lines are all high. A word load (`word_load`) moves the machine to `ST_ACTIVE` and captures the resolved code. Further loads in `ST_ACTIVE` or `ST_HOLD` stay in, or return to, `ST_ACTIVE` and recapture the code. An end of transfer (`xfer_end`) with no load returns the machine to `ST_IDLE`, or goes to `ST_HOLD` when `keep_act` is set. In `ST_HOLD` the lines stay as they were. Dropping `keep_act` leads back to `ST_IDLE`.

Top module: `spi_cs_decoder`

## Requirements
- R1: After reset, and in the idle state, `cs_n` is 4'hF, `cfg_set` is 0 and `no_target` is 1.
- R2: In direct mode (`decode_en`=0), at most one `cs_n` bit is low. For a code with bit i the lowest zero bit, `cs_n` has only bit i low and `cfg_set` equals i.
- R3: In direct mode, code 4'hF drives no line low, sets `no_target`=1 and gives `cfg_set`=0.
- R4: In decoded mode (`decode_en`=1), `cs_n` equals the 4-bit code and `cfg_set` equals code bits [3:2].
- R5: In decoded mode, code 4'hF asserts no peripheral: `cs_n`=4'hF and `no_target`=1, with `cfg_set`=3.
- R6: When `src_word`=0 the code is `mr_code`. When `src_word`=1 the code is `word_code`.
- R7: Outputs are captured on the clock edge where `word_load` is 1 and appear after that edge. Changes of `decode_en`, `src_word`, `mr_code` or `word_code` without a load have no effect on the outputs.
- R8: Back-to-back loads of the same code keep the selected line low in every cycle, with no high pulse between transfers.
- R9: `xfer_end` without a load and with `keep_act`=0 returns `cs_n` to 4'hF after the next edge. With `keep_act`=1 the lines hold until the next load, or until `keep_act` drops. A load in the same cycle as `xfer_end` takes priority.
- R10: `mfault_en` is 1 exactly when `keep_act` is 0.
- R11: `no_target` is 1 exactly when `cs_n` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decode_en | input | 1 | 1 = decoded mode, 0 = direct mode |
| src_word | input | 1 | 1 = code from the word field, 0 = from the fixed field |
| mr_code | input | 4 | Fixed select-code field |
| word_code | input | 4 | Select code carried with the transmit word |
| word_load | input | 1 | Shifter loads a new word this cycle |
| xfer_end | input | 1 | Shifter finishes with no further word |
| keep_act | input | 1 | Keep the select asserted after the last transfer |
| cs_n | output | 4 | Active-low select lines |
| cfg_set | output | 2 | Index of the per-select configuration set |
| no_target | output | 1 | No peripheral is addressed |
| mfault_en | output | 1 | Mode-fault sensing on line 0 is permitted |

## Verification
The assertions check on every cycle that direct mode never drives more than one line low, and that the idle state shows all lines high. They also check that `no_target` agrees with the lines, and that decoded-mode set indices match the upper code bits. Two further assertions cover the transfer-boundary rules: the lines stay stable with no event, and an end without keep releases them. Only the bench scenarios can show the exact line chosen for each code pattern and the choice between the two code sources. The same holds for the absence of a high pulse between back-to-back same-code loads, the hold-and-release sequence of the keep option, and load priority over an end in the same cycle.

// File: rtl/spi_csdec_pkg.sv
package spi_csdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } cs_state_e;

endpackage

// File: rtl/csdec_srcmux.sv
module csdec_srcmux #(
    parameter int NCS = 4
) (
    input  logic           src_word,
    input  logic [NCS-1:0] mr_code,
    input  logic [NCS-1:0] word_code,
    output logic [NCS-1:0] code
);

    always_comb begin
        if (src_word) code = word_code;
        else          code = mr_code;
    end

endmodule

// File: rtl/csdec_resolve.sv
module csdec_resolve #(
    parameter int NCS   = 4,
    parameter int SET_W = 2
) (
    input  logic             dec_mode,
    input  logic [NCS-1:0]   code,
    output logic [NCS-1:0]   lines,
    output logic [SET_W-1:0] set_idx,
    output logic             none
);

    // ones_below[i] is 1 when every code bit under position i is 1
    logic [NCS:0]     ones_below;
    logic [NCS-1:0]   pick;
    logic [SET_W-1:0] set_dir;

    assign ones_below[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < NCS; g++) begin : g_prio
            assign ones_below[g+1] = ones_below[g] & code[g];
            assign pick[g]         = ones_below[g] & ~code[g];
        end
    endgenerate

    always_comb begin
        set_dir = '0;
        for (int i = 0; i < NCS; i++) begin
            if (pick[i]) set_dir = SET_W'(i);
        end
    end

    always_comb begin
        if (dec_mode) begin
            lines   = code;
            set_idx = code[NCS-1 -: SET_W];
            none    = &code;
        end else begin
            lines   = ~pick;
            set_idx = set_dir;
            none    = ~|pick;
        end
    end

    always_comb begin
        assert ($countones(pick) <= 1) else $error("AST_ONE_PICK"); // R2
    end

endmodule

// File: rtl/csdec_fsm.sv
module csdec_fsm
    import spi_csdec_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_load,
    input  logic             xfer_end,
    input  logic             keep_act,
    input  logic             dec_mode,
    input  logic [NCS-1:0]   res_lines,
    input  logic [SET_W-1:0] res_set,
    input  logic             res_none,
    output logic [NCS-1:0]   cs_n,
    output logic [SET_W-1:0] cfg_set,
    output logic             no_target
);

    cs_state_e state_q, state_d;
    logic      dec_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (word_load) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (word_load)     state_d = ST_ACTIVE;
                else if (xfer_end) state_d = keep_act ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (word_load)      state_d = ST_ACTIVE;
                else if (!keep_act) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers: touched only at loads and on release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= '1;
            cfg_set   <= '0;
            no_target <= 1'b1;
            dec_q     <= 1'b0;
        end else if (word_load) begin
            cs_n      <= res_lines;
            cfg_set   <= res_set;
            no_target <= res_none;
            dec_q     <= dec_mode;
        end else if (state_d == ST_IDLE && state_q != ST_IDLE) begin
            cs_n      <= '1;
            cfg_set   <= '0;
            no_target <= 1'b1;
            dec_q     <= 1'b0;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cs_n == '1 && cfg_set == '0)); // R1

    AST_DIRECT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_q |-> ($countones(~cs_n) <= 1)); // R2

    AST_DEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q && state_q != ST_IDLE) |-> (cfg_set == cs_n[NCS-1 -: SET_W])); // R4

    AST_NT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        no_target == (cs_n == '1)); // R11

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !word_load && !xfer_end) |=> $stable(cs_n)); // R7

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && xfer_end && !word_load && !keep_act) |=> (cs_n == '1)); // R9

endmodule

// File: rtl/spi_cs_decoder.sv
module spi_cs_decoder #(
    parameter int NCS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   decode_en,
    input  logic                   src_word,
    input  logic [NCS-1:0]         mr_code,
    input  logic [NCS-1:0]         word_code,
    input  logic                   word_load,
    input  logic                   xfer_end,
    input  logic                   keep_act,
    output logic [NCS-1:0]         cs_n,
    output logic [$clog2(NCS)-1:0] cfg_set,
    output logic                   no_target,
    output logic                   mfault_en
);

    localparam int SET_W = $clog2(NCS);

    logic [NCS-1:0]   code;
    logic [NCS-1:0]   res_lines;
    logic [SET_W-1:0] res_set;
    logic             res_none;

    csdec_srcmux #(.NCS(NCS)) u_src (
        .src_word  (src_word),
        .mr_code   (mr_code),
        .word_code (word_code),
        .code      (code)
    );

    csdec_resolve #(.NCS(NCS), .SET_W(SET_W)) u_res (
        .dec_mode (decode_en),
        .code     (code),
        .lines    (res_lines),
        .set_idx  (res_set),
        .none     (res_none)
    );

    csdec_fsm #(.NCS(NCS), .SET_W(SET_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_load (word_load),
        .xfer_end  (xfer_end),
        .keep_act  (keep_act),
        .dec_mode  (decode_en),
        .res_lines (res_lines),
        .res_set   (res_set),
        .res_none  (res_none),
        .cs_n      (cs_n),
        .cfg_set   (cfg_set),
        .no_target (no_target)
    );

    // mode-fault sensing on line 0 is blocked while the select is kept active
    assign mfault_en = ~keep_act;

endmodule

// File: tb/spi_cs_decoder_test.sv
module spi_cs_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       decode_en = 1'b0, src_word = 1'b0;
    logic [3:0] mr_code = 4'hF, word_code = 4'hF;
    logic       word_load = 1'b0, xfer_end = 1'b0, keep_act = 1'b0;
    logic [3:0] cs_n;
    logic [1:0] cfg_set;
    logic       no_target, mfault_en;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_cs_decoder uut (
        .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .src_word(src_word),
        .mr_code(mr_code), .word_code(word_code), .word_load(word_load),
        .xfer_end(xfer_end), .keep_act(keep_act), .cs_n(cs_n),
        .cfg_set(cfg_set), .no_target(no_target), .mfault_en(mfault_en)
    );

    // {dec, src, mr, word, exp_cs, exp_set, exp_none}
    localparam int NV = 13;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'hE, 4'h0, 4'hE, 2'd0, 1'b0},  // R2 R6 fixed field
        {1'b0, 1'b1, 4'hE, 4'hB, 4'hB, 2'd2, 1'b0},  // R2 R6 word field
        {1'b0, 1'b0, 4'h5, 4'hF, 4'hD, 2'd1, 1'b0},  // R2 lowest zero wins
        {1'b0, 1'b0, 4'h0, 4'hF, 4'hE, 2'd0, 1'b0},  // R2 all zeros
        {1'b0, 1'b1, 4'h0, 4'h7, 4'h7, 2'd3, 1'b0},  // R2 line 3
        {1'b0, 1'b0, 4'hF, 4'h0, 4'hF, 2'd0, 1'b1},  // R3
        {1'b1, 1'b0, 4'h0, 4'hF, 4'h0, 2'd0, 1'b0},  // R4
        {1'b1, 1'b1, 4'hF, 4'h6, 4'h6, 2'd1, 1'b0},  // R4 R6
        {1'b1, 1'b1, 4'h0, 4'h9, 4'h9, 2'd2, 1'b0},  // R4
        {1'b1, 1'b0, 4'hE, 4'h0, 4'hE, 2'd3, 1'b0},  // R4 peripheral 14
        {1'b1, 1'b0, 4'hC, 4'h1, 4'hC, 2'd3, 1'b0},  // R4
        {1'b1, 1'b1, 4'h0, 4'hF, 4'hF, 2'd3, 1'b1},  // R5
        {1'b1, 1'b1, 4'h3, 4'h3, 4'h3, 2'd0, 1'b0}   // R4
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [3:0] ecs,
                             input logic [1:0] eset, input logic enone);
        check(req, {1'b0, enone, cfg_set, cs_n}, {1'b0, enone, eset, ecs});
        check({req, " no_target"}, {7'd0, no_target}, {7'd0, enone});
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        check_out("R1 reset", 4'hF, 2'd0, 1'b1);
        check("R10 mfault idle", {7'd0, mfault_en}, 8'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 4'hF, 2'd0, 1'b1);

        // table walk: load, check, end, check idle
        for (int v = 0; v < NV; v++) begin
            decode_en = VEC[v][16];
            src_word  = VEC[v][15];
            mr_code   = VEC[v][14:11];
            word_code = VEC[v][10:7];
            word_load = 1'b1;
            @(negedge clk);
            word_load = 1'b0;
            check_out($sformatf("vector %0d R2-table", v), VEC[v][6:3], VEC[v][2:1], VEC[v][0]);
            xfer_end = 1'b1;
            @(negedge clk);
            xfer_end = 1'b0;
            check_out("R9 release", 4'hF, 2'd0, 1'b1);
        end

        // R7: input changes without a load have no effect
        decode_en = 1'b0; src_word = 1'b0; mr_code = 4'hB; word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
        decode_en = 1'b1; mr_code = 4'h2; src_word = 1'b1; word_code = 4'h0;
        @(negedge clk);
        check_out("R7 no load", 4'hB, 2'd2, 1'b0);
        @(negedge clk);
        check_out("R7 still", 4'hB, 2'd2, 1'b0);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;

        // R8: back-to-back same code, line low every cycle
        decode_en = 1'b1; src_word = 1'b1; word_code = 4'h5; word_load = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_out("R8 back-to-back", 4'h5, 2'd1, 1'b0);
        end
        // R9: load and end together, load wins
        xfer_end = 1'b1; word_code = 4'h8;
        @(negedge clk);
        word_load = 1'b0; xfer_end = 1'b0;
        check_out("R9 load priority", 4'h8, 2'd2, 1'b0);

        // R9 and R10: keep option holds lines
        keep_act = 1'b1;
        #1;
        check("R10 mfault keep", {7'd0, mfault_en}, 8'd0);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
        check_out("R9 hold", 4'h8, 2'd2, 1'b0);
        @(negedge clk);
        check_out("R9 hold 2", 4'h8, 2'd2, 1'b0);
        keep_act = 1'b0;
        #1;
        check("R10 mfault off", {7'd0, mfault_en}, 8'd1);
        @(negedge clk);
        check_out("R9 keep drop", 4'hF, 2'd0, 1'b1);

        // R9: load from hold returns to active with new code
        keep_act = 1'b1; decode_en = 1'b0; src_word = 1'b0; mr_code = 4'h3; word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0; xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0; mr_code = 4'hD; word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
        check_out("R9 reload from hold", 4'hD, 2'd1, 1'b0);
        keep_act = 1'b0;
        @(negedge clk);
        check_out("R11 active kept", 4'hD, 2'd1, 1'b0);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
        check_out("R1 idle again", 4'hF, 2'd0, 1'b1);

        // R1: reset mid-transfer
        word_load = 1'b1; mr_code = 4'h1;
        @(negedge clk);
        word_load = 1'b0;
        rst_n = 1'b0;
        #1;
        check_out("R1 async reset", 4'hF, 2'd0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule